// File: doc/BRIEF.md
# Double-Buffered Timer PWM Generator

This block drives one pulse-width-modulated output. The time base is a ladder of three counters: a prescaler stage that divides the input clock by 1, 4 or 16; a 2-bit sub-count that advances once per prescaler wrap; and an 8-bit timer that advances once per sub-count wrap. The timer restarts after it reaches a programmable period value. The duty setting is ten bits wide. It is compared against the timer with the sub-count appended, so the high time has a resolution of one prescaled input clock rather than one timer step.

Software writes the period, the eight upper duty bits and a control byte through a simple write port. The control byte carries the two lower duty bits, the prescale code and the run enable. A duty written at any moment is held as pending. It moves into the active duty register only when a period starts, so a period in progress always finishes with the duty it started with.

A two-state controller sequences the block. **ST_IDLE** holds all counters at zero and the output low. The transition **start** (from ST_IDLE to ST_RUN, taken when enable is set) loads the active duty and begins a period. In **ST_RUN** the counters advance. The transition **rollover** (ST_RUN to ST_RUN, taken at the last clock of a period) clears the counters and reloads the duty. The transition **stop** (ST_RUN to ST_IDLE, taken when enable is clear) returns the block to its reset-like hold.

Top module: `pwm_dbuf_top`

## Requirements
- R1: After reset, pwm_out is low and every readable address (0 to 3) returns zero.
- R2: Address 0 holds the period value, address 1 holds duty bits [9:2], and address 2 holds the control byte. The control byte layout is: bits [1:0] duty bits [1:0], bits [3:2] prescale code, bit 4 enable, other bits read as zero. All three addresses read back what was written, and a write takes effect at the clock edge on which wr_en is sampled high.
- R3: Prescale code 00 divides by 1, code 01 divides by 4, and codes 10 and 11 both divide by 16.
- R4: While enabled, the output period is (period + 1) × 4 × divide input clocks.
- R5: Every period starts high and stays high for D × divide input clocks, where D = {duty[9:2], duty[1:0]}.
- R6: With D = 0 the output never goes high.
- R7: When D ≥ 4 × (period + 1), the output stays high without interruption, including across rollover.
- R8: A duty write during a period has no effect on that period and applies from the next one. Address 3 returns the active duty bits [9:2], and that value changes only at start or rollover.
- R9: A write to address 3 is ignored.
- R10: The clock edge after the enable bit is cleared forces the output low and clears the counters. The clock edge after the enable bit is set starts a period, with the output high if D is nonzero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 8 | Register read data (combinational) |
| pwm_out | output | 1 | PWM output |

## Verification
A register write takes effect at the edge that samples wr_en, and read data follows rd_addr in the same cycle. The controller reacts to a changed enable bit one edge later, so the output responds to an enable write on the second edge after the write is presented. The bench drives inputs on falling edges and advances its reference model (period position and pending and active duty) at each rising edge in that same order. It then compares pwm_out and the active-duty readback against the model on every falling edge. Period and high-time measurements count falling-edge samples from one rising output to the next, so each result is read exactly one half-clock after the register that produces it updates.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
    localparam int SUB_W = 2;
    localparam int PSC_W = 4;

    localparam logic [1:0] A_PERIOD = 2'd0;
    localparam logic [1:0] A_DUTY   = 2'd1;
    localparam logic [1:0] A_CTRL   = 2'd2;
    localparam logic [1:0] A_ACTIVE = 2'd3;

    localparam int C_DLO = 0;
    localparam int C_PSC = 2;
    localparam int C_EN  = 4;

    typedef enum logic {ST_IDLE, ST_RUN} run_state_t;

    function automatic logic [PSC_W-1:0] psc_last(input logic [1:0] code);
        logic [PSC_W-1:0] r;
        unique case (code)
            2'b00:   r = PSC_W'(0);
            2'b01:   r = PSC_W'(3);
            default: r = PSC_W'(15);
        endcase
        return r;
    endfunction
endpackage

// File: rtl/pwm_regs.sv
module pwm_regs
    import pwm_pkg::*;
#(
    parameter int TMR_W = 8,
    localparam int DUTY_W = TMR_W + SUB_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [TMR_W-1:0]  wr_data,
    input  logic [1:0]        rd_addr,
    input  logic [TMR_W-1:0]  act_hi,
    output logic [TMR_W-1:0]  rd_data,
    output logic [TMR_W-1:0]  period,
    output logic [DUTY_W-1:0] duty_pend,
    output logic [1:0]        psc_sel,
    output logic              enable
);
    logic [TMR_W-1:0] duty_hi;
    logic [SUB_W-1:0] duty_lo;
    logic [TMR_W-1:0] ctrl_view;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            period  <= '0;
            duty_hi <= '0;
            duty_lo <= '0;
            psc_sel <= '0;
            enable  <= 1'b0;
        end else if (wr_en) begin
            unique case (wr_addr)
                A_PERIOD: period  <= wr_data;
                A_DUTY:   duty_hi <= wr_data;
                A_CTRL: begin
                    duty_lo <= wr_data[C_DLO +: SUB_W];
                    psc_sel <= wr_data[C_PSC +: 2];
                    enable  <= wr_data[C_EN];
                end
                default: ;
            endcase
        end
    end

    assign duty_pend = {duty_hi, duty_lo};

    always_comb begin
        ctrl_view = '0;
        ctrl_view[C_DLO +: SUB_W] = duty_lo;
        ctrl_view[C_PSC +: 2]     = psc_sel;
        ctrl_view[C_EN]           = enable;
    end

    always_comb begin
        unique case (rd_addr)
            A_PERIOD: rd_data = period;
            A_DUTY:   rd_data = duty_hi;
            A_CTRL:   rd_data = ctrl_view;
            default:  rd_data = act_hi;
        endcase
    end

    assert_hold_without_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(period) && $stable(duty_pend) && $stable(psc_sel) && $stable(enable)));
endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase
    import pwm_pkg::*;
#(
    parameter int TMR_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [TMR_W-1:0] period,
    input  logic [1:0]       psc_sel,
    output logic [TMR_W-1:0] nxt_tmr,
    output logic [SUB_W-1:0] nxt_sub,
    output logic [PSC_W-1:0] nxt_p,
    output logic             load,
    output logic             run_nxt
);
    run_state_t       state, state_nxt;
    logic [TMR_W-1:0] tmr;
    logic [SUB_W-1:0] sub;
    logic [PSC_W-1:0] p;
    logic [PSC_W-1:0] p_last;
    logic             p_wrap, sub_wrap, roll;

    assign p_last   = psc_last(psc_sel);
    assign p_wrap   = (p >= p_last);
    assign sub_wrap = p_wrap && (sub == {SUB_W{1'b1}});
    assign roll     = sub_wrap && (tmr == period);

    always_comb begin
        state_nxt = state;
        load      = 1'b0;
        nxt_tmr   = '0;
        nxt_sub   = '0;
        nxt_p     = '0;
        unique case (state)
            ST_IDLE: begin
                if (enable) begin
                    state_nxt = ST_RUN;
                    load      = 1'b1;
                end
            end
            ST_RUN: begin
                if (!enable) begin
                    state_nxt = ST_IDLE;
                end else if (roll) begin
                    load = 1'b1;
                end else begin
                    nxt_p   = p_wrap ? '0 : p + 1'b1;
                    nxt_sub = p_wrap ? sub + 1'b1 : sub;
                    nxt_tmr = sub_wrap ? tmr + 1'b1 : tmr;
                end
            end
            default: state_nxt = ST_IDLE;
        endcase
    end

    assign run_nxt = (state_nxt == ST_RUN);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            tmr   <= '0;
            sub   <= '0;
            p     <= '0;
        end else begin
            state <= state_nxt;
            tmr   <= nxt_tmr;
            sub   <= nxt_sub;
            p     <= nxt_p;
        end
    end

    assert_idle_counts_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> (tmr == '0 && sub == '0 && p == '0));
endmodule

// File: rtl/pwm_outstage.sv
module pwm_outstage
    import pwm_pkg::*;
#(
    parameter int TMR_W = 8,
    localparam int DUTY_W = TMR_W + SUB_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              run_nxt,
    input  logic [TMR_W-1:0]  nxt_tmr,
    input  logic [SUB_W-1:0]  nxt_sub,
    input  logic [PSC_W-1:0]  nxt_p,
    input  logic [DUTY_W-1:0] duty_pend,
    output logic [DUTY_W-1:0] duty_act,
    output logic              pwm_out
);
    logic hit;

    assign hit = ({nxt_tmr, nxt_sub} == duty_act) && (nxt_p == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            duty_act <= '0;
            pwm_out  <= 1'b0;
        end else if (load) begin
            duty_act <= duty_pend;
            pwm_out  <= |duty_pend;
        end else if (!run_nxt || hit) begin
            pwm_out  <= 1'b0;
        end
    end

    assert_zero_duty_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (duty_act == '0) |-> !pwm_out);
    assert_active_only_at_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(duty_act));
    assert_rise_at_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pwm_out) |-> $past(load));
endmodule

// File: rtl/pwm_dbuf_top.sv
module pwm_dbuf_top
    import pwm_pkg::*;
#(
    parameter int TMR_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [TMR_W-1:0] wr_data,
    input  logic [1:0]       rd_addr,
    output logic [TMR_W-1:0] rd_data,
    output logic             pwm_out
);
    localparam int DUTY_W = TMR_W + SUB_W;

    logic [TMR_W-1:0]  period;
    logic [DUTY_W-1:0] duty_pend, duty_act;
    logic [1:0]        psc_sel;
    logic              enable;
    logic [TMR_W-1:0]  nxt_tmr;
    logic [SUB_W-1:0]  nxt_sub;
    logic [PSC_W-1:0]  nxt_p;
    logic              load, run_nxt;

    pwm_regs #(.TMR_W(TMR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .act_hi(duty_act[DUTY_W-1:SUB_W]),
        .rd_data(rd_data), .period(period), .duty_pend(duty_pend),
        .psc_sel(psc_sel), .enable(enable)
    );

    pwm_timebase #(.TMR_W(TMR_W)) u_timebase (
        .clk(clk), .rst_n(rst_n), .enable(enable), .period(period),
        .psc_sel(psc_sel), .nxt_tmr(nxt_tmr), .nxt_sub(nxt_sub),
        .nxt_p(nxt_p), .load(load), .run_nxt(run_nxt)
    );

    pwm_outstage #(.TMR_W(TMR_W)) u_outstage (
        .clk(clk), .rst_n(rst_n), .load(load), .run_nxt(run_nxt),
        .nxt_tmr(nxt_tmr), .nxt_sub(nxt_sub), .nxt_p(nxt_p),
        .duty_pend(duty_pend), .duty_act(duty_act), .pwm_out(pwm_out)
    );

    assert_disable_forces_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !pwm_out);
endmodule

// File: tb/test_pwm_dbuf_top.sv
module test_pwm_dbuf_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [1:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       pwm_out;

    int checks = 0;
    int errors = 0;
    string cur_req = "R1";

    // reference model state
    int  m_pr = 0, m_dhi = 0, m_dlo = 0, m_psc = 0;
    bit  m_en = 0, m_run = 0;
    int  pos = 0, dact = 0;
    bit  exp_out = 0;

    always #5 clk = ~clk;

    pwm_dbuf_top i_pwm_dbuf_top (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .pwm_out(pwm_out)
    );

    function automatic int div_of(int code);
        if (code == 0) return 1;
        if (code == 1) return 4;
        return 16;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_pr = 0; m_dhi = 0; m_dlo = 0; m_psc = 0; m_en = 0;
            m_run = 0; pos = 0; dact = 0; exp_out = 0;
        end else begin
            int len;
            len = (m_pr + 1) * 4 * div_of(m_psc);
            if (!m_run) begin
                if (m_en) begin m_run = 1; pos = 0; dact = m_dhi * 4 + m_dlo; end
            end else if (!m_en) begin
                m_run = 0; pos = 0;
            end else begin
                pos = pos + 1;
                if (pos == len) begin pos = 0; dact = m_dhi * 4 + m_dlo; end
            end
            exp_out = m_run && (pos < dact * div_of(m_psc));
            if (wr_en) begin
                case (wr_addr)
                    2'd0: m_pr = wr_data;
                    2'd1: m_dhi = wr_data;
                    2'd2: begin m_dlo = wr_data[1:0]; m_psc = wr_data[3:2]; m_en = wr_data[4]; end
                    default: ;
                endcase
            end
        end
    end

    task automatic check(string req, int act, int exp, string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // every-clock comparison against the model
    always @(negedge clk) begin
        if (rst_n) begin
            check(cur_req, pwm_out, exp_out, "pwm_out vs model");
            if (rd_addr == 2'd3) check("R8", rd_data, dact / 4, "active duty readback");
        end
    end

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_check(string req, input logic [1:0] a, int exp);
        rd_addr = a;
        #1;
        check(req, rd_data, exp, "register readback");
        rd_addr = 2'd3;
    endtask

    task automatic measure(string req, int exp_hi, int exp_per);
        int hi = 0, per = 0, guard = 0;
        bit fallen = 0;
        do begin @(negedge clk); guard++; end while (pwm_out && guard < 5000);
        do begin @(negedge clk); guard++; end while (!pwm_out && guard < 10000);
        forever begin
            per++;
            if (pwm_out && !fallen) hi++;
            else fallen = 1;
            @(negedge clk);
            guard++;
            if ((fallen && pwm_out) || guard > 20000) break;
        end
        check(req, hi, exp_hi, "high time clocks");
        check(req, per, exp_per, "period clocks");
    endtask

    task automatic count_level(string req, int n, bit lvl, int exp);
        int c = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (pwm_out == lvl) c++;
        end
        check(req, c, exp, "level count");
    endtask

    initial begin
        #(200000 * 10);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rd_addr = 2'd0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check("R1", pwm_out, 0, "pwm_out after reset");
        for (int a = 0; a < 4; a++) begin
            rd_addr = 2'(a); #1;
            check("R1", rd_data, 0, "readback after reset");
        end
        rd_addr = 2'd3;

        // R2 readback of period, duty, control
        cur_req = "R2";
        wr(2'd0, 8'd3);
        wr(2'd1, 8'h05);
        wr(2'd2, 8'h0A);
        rd_check("R2", 2'd0, 3);
        rd_check("R2", 2'd1, 5);
        rd_check("R2", 2'd2, 8'h0A);
        wr(2'd2, 8'h00);

        // R4 R5 divide by 1: period 9, D=22
        cur_req = "R5";
        wr(2'd0, 8'd9);
        wr(2'd1, 8'd5);
        wr(2'd2, 8'h12);
        measure("R5", 22, 40);

        // R3 divide by 4: period 4, D=7
        cur_req = "R3";
        wr(2'd2, 8'h00);
        wr(2'd0, 8'd4);
        wr(2'd1, 8'd1);
        wr(2'd2, 8'h17);
        measure("R3", 28, 80);

        // R3 R4 divide by 16 (code 11 then code 10): period 2, D=5
        cur_req = "R4";
        wr(2'd2, 8'h00);
        wr(2'd0, 8'd2);
        wr(2'd2, 8'h1D);
        measure("R4", 80, 192);
        wr(2'd2, 8'h00);
        wr(2'd2, 8'h19);
        measure("R3", 80, 192);

        // R6 zero duty
        cur_req = "R6";
        wr(2'd2, 8'h00);
        wr(2'd1, 8'd0);
        wr(2'd2, 8'h10);
        count_level("R6", 300, 1'b1, 0);

        // R7 duty beyond period: period 3 (16 clocks), D=20
        cur_req = "R7";
        wr(2'd2, 8'h00);
        wr(2'd0, 8'd3);
        wr(2'd1, 8'd5);
        wr(2'd2, 8'h10);
        @(negedge clk);
        count_level("R7", 100, 1'b0, 0);

        // R8 mid-period duty write: period 19 (80 clocks), D=10 then 42
        cur_req = "R8";
        wr(2'd2, 8'h00);
        wr(2'd0, 8'd19);
        wr(2'd1, 8'd2);
        wr(2'd2, 8'h12);
        do @(negedge clk); while (!pwm_out);
        repeat (3) @(negedge clk);
        wr(2'd1, 8'd10);
        check("R8", rd_data, 2, "active duty unchanged mid-period");
        begin
            int hi = 5;
            while (pwm_out) begin hi++; @(negedge clk); end
            check("R8", hi, 10, "current period high time after mid-period write");
        end
        measure("R8", 42, 80);

        // R9 write to active address ignored
        cur_req = "R9";
        wr(2'd3, 8'hFF);
        check("R9", rd_data, 10, "active duty after write to address 3");
        measure("R9", 42, 80);

        // R10 disable then enable timing
        cur_req = "R10";
        do @(negedge clk); while (!pwm_out);
        wr(2'd2, 8'h02);
        check("R10", pwm_out, 1, "output one edge after disable write");
        @(negedge clk);
        check("R10", pwm_out, 0, "output low after disable");
        wr(2'd2, 8'h12);
        check("R10", pwm_out, 0, "output before start edge");
        @(negedge clk);
        check("R10", pwm_out, 1, "output high at period start");
        repeat (20) @(negedge clk);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule